// File: doc/BRIEF.md
# Loop Frequency-Response Stability Checker

This block walks a stored complex loop frequency response, one real/imaginary pair per frequency bin, and decides whether a candidate compensator gives an acceptable loop. Three tests run in the same pass. The first finds where the loop phase first reaches -180 degrees and compares the loop magnitude there against a gain-margin limit. The second confirms that the loop passes through unity gain only around the target crossover bin. The third finds where the phase first reaches -45 degrees and rejects a loop whose low-frequency gain flattens out before crossover.

Phase points are found only from the signs and relative sizes of the real and imaginary parts, so no angle is computed. Magnitudes are compared as squared values, so no square root is taken. A tuning engine writes the response into a RAM, places the target bin and the squared gain-margin limit on the inputs, and pulses `start`. The block reads bins 1 through NBINS-1, one per clock, from a RAM with a one-cycle read latency. It then pulses `done` and holds the three per-test flags and their combined pass bit until the next scan.

Top module: `loop_resp_check`

## Requirements
- R1: After reset, `busy`, `done`, `gm_ok`, `xover_ok`, `flat_ok` and `pass` are all 0.
- R2: A `start` seen while idle launches a scan that presents bin addresses 1, 2, ..., NBINS-1 on consecutive cycles with `ram_rd` high. The RAM returns data one cycle after the address. `done` is high for exactly one cycle, NBINS cycles after the launching edge, and the result flags hold their values from then until the next launch.
- R3: Samples are two's complement with FRAC fractional bits, so unity is 2^FRAC. The -180 degree bin is the lowest bin with re < 0 and im > 0. `gm_ok` is 1 when no such bin exists, or when re^2+im^2 at that bin is strictly less than `gm_lim`. A 10 dB margin corresponds to `gm_lim` = 0.1 * 2^(2*FRAC).
- R4: Only the first -180 degree bin decides `gm_ok`. Later bins that meet the same sign condition have no effect.
- R5: `xover_ok` is 0 exactly when some bin k with 1 <= k < `tgt_bin` has re^2+im^2 < 2^(2*FRAC), or some bin k > `tgt_bin` has re^2+im^2 > 2^(2*FRAC). The target bin itself, and a squared magnitude exactly equal to unity, never fail this test.
- R6: The -45 degree bin is the lowest bin with re > 0, im < 0 and |re| > |im|. `flat_ok` is 0 exactly when such a bin exists and its index is below `tgt_bin`.
- R7: `pass` is 1 exactly when `gm_ok`, `xover_ok` and `flat_ok` are all 1.
- R8: `tgt_bin` and `gm_lim` are captured at the launching edge. A `start` that arrives while `busy` is high is ignored and does not change the scan or its results.
- R9: Bin 0 (dc) is never read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, honoured only while idle |
| tgt_bin | input | AW | Target crossover bin index |
| gm_lim | input | MW | Squared gain-margin limit, same scale as re^2+im^2 |
| ram_rd | output | 1 | Read enable to the response RAM |
| ram_addr | output | AW | Bin address to the response RAM |
| ram_re | input | DW | Real part returned one cycle after the address |
| ram_im | input | DW | Imaginary part returned one cycle after the address |
| busy | output | 1 | High from the launch until `done` |
| done | output | 1 | One-cycle end-of-scan strobe |
| gm_ok | output | 1 | Gain-margin test result |
| xover_ok | output | 1 | Single-crossover test result |
| flat_ok | output | 1 | Low-frequency flattening test result |
| pass | output | 1 | All three tests passed |

## Verification
A directed baseline response, with high gain below the target bin and low gain above it, is perturbed one bin at a time. Each perturbation isolates one test: a late -45 degree point against an early one, a weak first -180 degree point followed by a large later one, and a dip or bump on either side of the target. Squared magnitudes exactly equal to unity or to the limit, a target at bin 1, and a mid-scan `start` carrying a different target check the boundaries and the capture rule. Seeded random responses, either fully random or a structured baseline with scattered random bins, are compared against a bench model of the three tests. The bench also watches the RAM port for the address order, the read count and any read of bin 0.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    // Per-bin classification produced by the sample classifier
    typedef struct packed {
        logic is_m180;   // phase at -180 deg: re < 0, im > 0
        logic is_m45;    // phase at -45 deg: re > 0, im < 0, |re| > |im|
        logic below_one; // squared magnitude below unity
        logic above_one; // squared magnitude above unity
    } bin_cls_t;

endpackage

// File: rtl/lrc_scan.sv
module lrc_scan #(
    parameter int NBINS = 1024,
    localparam int AW = $clog2(NBINS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          launch,
    output logic          busy,
    output logic          rd_en,
    output logic [AW-1:0] addr,
    output logic          vld,
    output logic [AW-1:0] vbin,
    output logic          last
);

    localparam logic [AW-1:0] LAST_BIN = AW'(NBINS - 1);

    typedef struct packed {
        logic          busy;
        logic          rd;
        logic [AW-1:0] addr;
        logic          vld;
        logic [AW-1:0] vbin;
    } scan_st_t;

    scan_st_t st_q, st_d;

    assign launch = start && !st_q.busy;
    assign last   = st_q.vld && (st_q.vbin == LAST_BIN);

    always_comb begin
        st_d      = st_q;
        // RAM data for the address issued this cycle arrives next cycle
        st_d.vld  = st_q.rd;
        st_d.vbin = st_q.addr;
        if (launch) begin
            st_d.busy = 1'b1;
            st_d.rd   = 1'b1;
            st_d.addr = AW'(1);
        end else if (st_q.rd) begin
            if (st_q.addr == LAST_BIN) begin
                st_d.rd = 1'b0;
            end else begin
                st_d.addr = st_q.addr + 1'b1;
            end
        end
        if (last) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = st_q.busy;
    assign rd_en = st_q.rd;
    assign addr  = st_q.addr;
    assign vld   = st_q.vld;
    assign vbin  = st_q.vbin;

    // Consecutive reads walk the bins upward one at a time
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && $past(rd_en) |-> addr == $past(addr) + 1'b1);

    // A launch starts reading at bin 1, never at dc
    assert_first_bin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> rd_en && addr == AW'(1));

    assert_no_dc_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> addr != '0);

endmodule

// File: rtl/lrc_classify.sv
module lrc_classify
    import lrc_pkg::*;
#(
    parameter int DW   = 18,
    parameter int FRAC = 14,
    localparam int MW  = 2 * DW + 1
) (
    input  logic signed [DW-1:0] re,
    input  logic signed [DW-1:0] im,
    output bin_cls_t             cls,
    output logic [MW-1:0]        mag2
);

    localparam logic [MW-1:0] UNITY2 = MW'(1) << (2 * FRAC);

    logic signed [2*DW-1:0] re_x, im_x, re_sq, im_sq;
    logic [DW:0] re_mag, im_neg_mag;
    logic re_neg, re_pos, im_neg, im_pos;

    always_comb begin
        re_x   = {{DW{re[DW-1]}}, re};
        im_x   = {{DW{im[DW-1]}}, im};
        re_sq  = re_x * re_x;
        im_sq  = im_x * im_x;
        mag2   = {1'b0, re_sq} + {1'b0, im_sq};

        re_neg = re[DW-1];
        im_neg = im[DW-1];
        re_pos = !re[DW-1] && (re != '0);
        im_pos = !im[DW-1] && (im != '0);

        // Only used when re > 0 and im < 0
        re_mag     = {1'b0, re};
        im_neg_mag = -{im[DW-1], im};

        cls.is_m180   = re_neg && im_pos;
        cls.is_m45    = re_pos && im_neg && (re_mag > im_neg_mag);
        cls.below_one = mag2 < UNITY2;
        cls.above_one = mag2 > UNITY2;
    end

endmodule

// File: rtl/lrc_verdict.sv
module lrc_verdict
    import lrc_pkg::*;
#(
    parameter int NBINS = 1024,
    parameter int DW    = 18,
    localparam int AW   = $clog2(NBINS),
    localparam int MW   = 2 * DW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          vld,
    input  logic [AW-1:0] vbin,
    input  logic          last,
    input  bin_cls_t      cls,
    input  logic [MW-1:0] mag2,
    input  logic [AW-1:0] tgt_bin,
    input  logic [MW-1:0] gm_lim,
    output logic          done,
    output logic          gm_ok,
    output logic          xover_ok,
    output logic          flat_ok,
    output logic          pass
);

    typedef struct packed {
        logic [AW-1:0] tgt;
        logic [MW-1:0] lim;
        logic          seen180;
        logic          gm_bad;
        logic          seen45;
        logic          flat_bad;
        logic          xo_bad;
        logic          done;
        logic          gm_ok;
        logic          xo_ok;
        logic          fl_ok;
        logic          pass;
    } vrd_st_t;

    vrd_st_t v_q, v_d;

    always_comb begin
        v_d      = v_q;
        v_d.done = 1'b0;
        if (launch) begin
            v_d          = '0;
            v_d.tgt      = tgt_bin;
            v_d.lim      = gm_lim;
        end else if (vld) begin
            if (cls.is_m180 && !v_q.seen180) begin
                v_d.seen180 = 1'b1;
                v_d.gm_bad  = !(mag2 < v_q.lim);
            end
            if (cls.is_m45 && !v_q.seen45) begin
                v_d.seen45   = 1'b1;
                v_d.flat_bad = vbin < v_q.tgt;
            end
            if ((vbin < v_q.tgt) && cls.below_one) begin
                v_d.xo_bad = 1'b1;
            end
            if ((vbin > v_q.tgt) && cls.above_one) begin
                v_d.xo_bad = 1'b1;
            end
            if (last) begin
                v_d.done  = 1'b1;
                v_d.gm_ok = !v_d.gm_bad;
                v_d.xo_ok = !v_d.xo_bad;
                v_d.fl_ok = !v_d.flat_bad;
                v_d.pass  = !(v_d.gm_bad || v_d.xo_bad || v_d.flat_bad);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q <= v_d;
        end
    end

    assign done     = v_q.done;
    assign gm_ok    = v_q.gm_ok;
    assign xover_ok = v_q.xo_ok;
    assign flat_ok  = v_q.fl_ok;
    assign pass     = v_q.pass;

    // End-of-scan strobe lasts a single cycle
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Results move only at a launch or while bins are being consumed
    assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !launch && !vld |=> $stable({gm_ok, xover_ok, flat_ok, pass}));

    // Captured target stays put for the whole scan
    assert_tgt_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> $stable(v_q.tgt) && $stable(v_q.lim));

    // Only a launch clears a decided gain-margin bin
    assert_first_m180_R4: assert property (@(posedge clk) disable iff (!rst_n)
        v_q.seen180 && !launch |=> v_q.seen180 && $stable(v_q.gm_bad));

endmodule

// File: rtl/loop_resp_check.sv
module loop_resp_check
    import lrc_pkg::*;
#(
    parameter int NBINS = 1024,
    parameter int DW    = 18,
    parameter int FRAC  = 14,
    localparam int AW   = $clog2(NBINS),
    localparam int MW   = 2 * DW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AW-1:0]        tgt_bin,
    input  logic [MW-1:0]        gm_lim,
    output logic                 ram_rd,
    output logic [AW-1:0]        ram_addr,
    input  logic signed [DW-1:0] ram_re,
    input  logic signed [DW-1:0] ram_im,
    output logic                 busy,
    output logic                 done,
    output logic                 gm_ok,
    output logic                 xover_ok,
    output logic                 flat_ok,
    output logic                 pass
);

    logic          launch_w, vld_w, last_w;
    logic [AW-1:0] vbin_w;
    bin_cls_t      cls_w;
    logic [MW-1:0] mag2_w;

    lrc_scan #(.NBINS(NBINS)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .launch (launch_w),
        .busy   (busy),
        .rd_en  (ram_rd),
        .addr   (ram_addr),
        .vld    (vld_w),
        .vbin   (vbin_w),
        .last   (last_w)
    );

    lrc_classify #(.DW(DW), .FRAC(FRAC)) u_cls (
        .re   (ram_re),
        .im   (ram_im),
        .cls  (cls_w),
        .mag2 (mag2_w)
    );

    lrc_verdict #(.NBINS(NBINS), .DW(DW)) u_vrd (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch_w),
        .vld      (vld_w),
        .vbin     (vbin_w),
        .last     (last_w),
        .cls      (cls_w),
        .mag2     (mag2_w),
        .tgt_bin  (tgt_bin),
        .gm_lim   (gm_lim),
        .done     (done),
        .gm_ok    (gm_ok),
        .xover_ok (xover_ok),
        .flat_ok  (flat_ok),
        .pass     (pass)
    );

    // No reads are issued once the scan has reported
    assert_quiet_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ram_rd && !busy);

    // A start during a scan does not restart the address walk
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && ram_rd |=> ram_addr != AW'(1));

endmodule

// File: tb/tb_loop_resp_check.sv
module tb_loop_resp_check;

    localparam int NBINS = 1024;
    localparam int DW    = 18;
    localparam int FRAC  = 14;
    localparam int AW    = $clog2(NBINS);
    localparam int MW    = 2 * DW + 1;
    localparam longint GM10 = 26843545; // 0.1 * 2^28

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] tgt_bin = '0;
    logic [MW-1:0] gm_lim = '0;
    logic ram_rd;
    logic [AW-1:0] ram_addr;
    logic signed [DW-1:0] ram_re, ram_im;
    logic busy, done, gm_ok, xover_ok, flat_ok, pass;

    logic signed [DW-1:0] re_mem [NBINS];
    logic signed [DW-1:0] im_mem [NBINS];

    int errors = 0;
    int checks = 0;

    // RAM port statistics
    logic clr_stats = 1'b0;
    int   n_reads = 0;
    int   order_err = 0;
    bit   dc_seen = 1'b0;
    bit   prev_rd = 1'b0;
    logic [AW-1:0] prev_addr = '0;

    always #4 clk = ~clk;

    loop_resp_check #(.NBINS(NBINS), .DW(DW), .FRAC(FRAC)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_bin(tgt_bin), .gm_lim(gm_lim),
        .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_re(ram_re), .ram_im(ram_im),
        .busy(busy), .done(done), .gm_ok(gm_ok), .xover_ok(xover_ok),
        .flat_ok(flat_ok), .pass(pass)
    );

    always @(posedge clk) begin
        if (ram_rd) begin
            ram_re <= re_mem[ram_addr];
            ram_im <= im_mem[ram_addr];
        end
        if (clr_stats) begin
            n_reads   <= 0;
            order_err <= 0;
            dc_seen   <= 1'b0;
            prev_rd   <= 1'b0;
        end else begin
            prev_rd   <= ram_rd;
            prev_addr <= ram_addr;
            if (ram_rd) begin
                n_reads <= n_reads + 1;
                if (ram_addr == '0) dc_seen <= 1'b1;
                if (prev_rd && ram_addr != prev_addr + 1'b1) order_err <= order_err + 1;
            end
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bench model of the three tests, bit order {gm, xover, flat, pass}
    function automatic logic [3:0] ref_eval(input int tgt, input longint lim);
        bit s180 = 0, s45 = 0, g = 1, x = 1, f = 1;
        longint unity2 = longint'(1) << (2 * FRAC);
        for (int k = 1; k < NBINS; k++) begin
            longint r = re_mem[k];
            longint i = im_mem[k];
            longint m = r * r + i * i;
            if (!s180 && r < 0 && i > 0) begin s180 = 1; g = (m < lim); end
            if (!s45 && r > 0 && i < 0 && r > -i) begin s45 = 1; f = !(k < tgt); end
            if (k < tgt && m < unity2) x = 0;
            if (k > tgt && m > unity2) x = 0;
        end
        return {g, x, f, g && x && f};
    endfunction

    function automatic void fill_base(input int tgt);
        for (int k = 0; k < NBINS; k++) begin
            if (k < tgt) begin re_mem[k] = 0; im_mem[k] = -18'sd32768; end
            else begin re_mem[k] = -18'sd4096; im_mem[k] = -18'sd4096; end
        end
        re_mem[tgt] = 18'sd8000; im_mem[tgt] = -18'sd4000;
        re_mem[300] = -18'sd2048; im_mem[300] = 18'sd2048;
    endfunction

    function automatic logic signed [DW-1:0] rnd_val();
        int v = int'($urandom_range(0, 262143)) - 131072;
        v = v >>> $urandom_range(0, 7);
        return DW'(v);
    endfunction

    task automatic run(input string tag, input int tgt, input longint lim, input bit mid_start);
        logic [3:0] exp = ref_eval(tgt, lim);
        logic [3:0] got;
        int cnt = 0;
        @(negedge clk);
        clr_stats = 1'b1; tgt_bin = AW'(tgt); gm_lim = MW'(lim); start = 1'b1;
        @(negedge clk);
        clr_stats = 1'b0; start = 1'b0;
        while (!done && cnt < 4000) begin
            @(negedge clk);
            cnt++;
            if (mid_start && cnt == 300) begin
                tgt_bin = AW'(900); gm_lim = '0; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        check({tag, " R2 done latency"}, cnt, NBINS);
        got = {gm_ok, xover_ok, flat_ok, pass};
        check({tag, " R3 gm_ok"}, got[3], exp[3]);
        check({tag, " R5 xover_ok"}, got[2], exp[2]);
        check({tag, " R6 flat_ok"}, got[1], exp[1]);
        check({tag, " R7 pass"}, got[0], exp[0]);
        check({tag, " R2 read count"}, n_reads, NBINS - 1);
        check({tag, " R2 read order"}, order_err, 0);
        check({tag, " R9 dc read"}, dc_seen, 0);
        @(negedge clk);
        check({tag, " R2 done one cycle"}, done, 0);
        repeat (5) @(negedge clk);
        check({tag, " R2 results held"}, {gm_ok, xover_ok, flat_ok, pass}, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < NBINS; k++) begin re_mem[k] = 0; im_mem[k] = 0; end
        repeat (3) @(negedge clk);
        check("R1 reset flags", {busy, done, gm_ok, xover_ok, flat_ok, pass}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {busy, done, pass}, 0);

        fill_base(100);                                     run("D1 R7 clean", 100, GM10, 0);
        fill_base(100); re_mem[99] = 18'sd20000; im_mem[99] = -18'sd10000;
                                                            run("D2 R6 early m45", 100, GM10, 0);
        fill_base(100); re_mem[300] = -18'sd8000; im_mem[300] = 18'sd8000;
                                                            run("D3 R3 weak margin", 100, GM10, 0);
        fill_base(100); re_mem[400] = -18'sd8000; im_mem[400] = 18'sd8000;
                                                            run("D4 R4 first m180 only", 100, GM10, 0);
        fill_base(100); re_mem[50] = 0; im_mem[50] = -18'sd100;
                                                            run("D5 R5 dip below", 100, GM10, 0);
        fill_base(100); re_mem[700] = 0; im_mem[700] = -18'sd20000;
                                                            run("D6 R5 bump above", 100, GM10, 0);
        fill_base(100); re_mem[300] = -18'sd4096; im_mem[300] = -18'sd4096;
                                                            run("D7 R3 no m180", 100, GM10, 0);
        fill_base(100); re_mem[100] = 18'sd100; im_mem[100] = -18'sd50;
                                                            run("D8 R5 target exempt", 100, GM10, 0);
        fill_base(100); re_mem[10] = 18'sd16384; im_mem[10] = 0;
                                                            run("D9 R5 unity equal", 100, GM10, 0);
        fill_base(100);                                     run("D10 R3 limit equal", 100, 8388608, 0);
        fill_base(100);                                     run("D11 R8 start while busy", 100, GM10, 1);
        fill_base(1);                                       run("D12 R5 target bin 1", 1, GM10, 0);

        for (int n = 0; n < 8; n++) begin
            int t = int'($urandom_range(1, NBINS - 1));
            if (n % 2 == 0) begin
                for (int k = 0; k < NBINS; k++) begin re_mem[k] = rnd_val(); im_mem[k] = rnd_val(); end
            end else begin
                fill_base(t > 300 ? 200 : t);
                for (int j = 0; j < 4; j++) begin
                    int b = int'($urandom_range(1, NBINS - 1));
                    re_mem[b] = rnd_val(); im_mem[b] = rnd_val();
                end
            end
            run($sformatf("RND%0d R3 R5 R6 R7", n), t,
                longint'($urandom_range(0, 32'h7fffffff)) >>> $urandom_range(0, 6), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule